// File: doc/BRIEF.md
# Per-CPU Clock Gate Controller

This block takes one free-running clock and produces a separate gated clock for each processor in a small multiprocessor. Each processor reports when it has gone idle and when an interrupt is waiting. The block turns that processor's clock off while it is idle and turns it back on as soon as an interrupt is pending. The free-running clock is never gated, so bus-side and snoop logic keep working while processor clocks are stopped.

An elaboration-time option selects a different control source. In that mode, a per-processor power-down vector from a debug unit controls each gate. That vector already accounts for pending interrupts and for moves into debug state, so the block adds no interrupt logic of its own in that mode.

Each enable is registered on the free-running clock. A latch that is transparent while the clock is low then holds it, and the latch output is ANDed with the clock. Every gated pulse is therefore a whole pulse, phase-aligned with the source clock. After reset only processor 0 is clocked. All other processors start powered down.

Top module: `cpu_clk_gate`

## Requirements
- R1: In idle-source mode (PD_SRC = 0), a processor with idle = 1 and interrupt-pending = 0 on an edge of the free-running clock produces no gated edge at the next edge or after it, for as long as that condition holds.
- R2: In idle-source mode, when a processor's interrupt-pending input goes to 1 while its clock is gated, the gated clock gives no edge at the first free-running edge and gives an edge at the second, whatever its idle input is.
- R3: In idle-source mode, a processor with idle = 0 gets one gated edge for every free-running edge, starting from the second edge after idle falls.
- R4: In debug-source mode (PD_SRC = 1), a processor's gated clock runs while its power-down bit is 0 and stops while it is 1, following the same two-edge timing. Its idle and interrupt-pending inputs have no effect.
- R5: While the active-low reset is asserted, and afterwards until some input calls for a change, processor 0's gated clock runs and every other processor's gated clock is stopped.
- R6: A gated clock is never high while the free-running clock is low. Gating never produces a truncated pulse or an extra edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running source clock, never gated |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuIdle | input | NUM_CPU | Per-processor idle (power-down entered) flag |
| irqPend | input | NUM_CPU | Per-processor interrupt-pending flag |
| dbgPwrDown | input | NUM_CPU | Per-processor power-down vector from a debug unit, used when PD_SRC = 1 |
| gclk | output | NUM_CPU | Per-processor gated clock |

## Verification
An input that changes between clock edges is captured by the enable register at the next rising edge. The latch passes the new enable during the following low phase, so the first gated edge that shows the change comes one full cycle after capture. The bench drives every input on a falling edge and ignores the one or two gated edges that still belong to the old state. It then counts gated edges per processor over fixed windows and reads the counts on falling edges, so no count depends on the order of events at a rising edge. For wake-up, it checks a count of zero after one cycle and exactly one edge after two. A monitor also samples every gated clock just after each falling edge of the source clock.

// File: rtl/cpu_clk_gate_pkg.sv
package cpu_clk_gate_pkg;

  // Selects which input vector decides the gate state
  typedef enum logic {
    SRC_IDLE  = 1'b0,
    SRC_DEBUG = 1'b1
  } pdSrc_e;

  // Enable pattern applied during reset: only processor 0 runs
  function automatic logic [7:0] resetPattern(input int unsigned numCpu);
    logic [7:0] pat;
    pat = '0;
    if (numCpu > 0) pat[0] = 1'b1;
    return pat;
  endfunction

endpackage

// File: rtl/cpu_clk_gate_ctrl.sv
module cpu_clk_gate_ctrl
  import cpu_clk_gate_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter bit          PD_SRC  = 1'b0,
  parameter type         strobe_t = logic
) (
  input  logic [NUM_CPU-1:0] cpuIdle,
  input  logic [NUM_CPU-1:0] irqPend,
  input  logic [NUM_CPU-1:0] dbgPwrDown,
  output strobe_t            strobes
);

  localparam pdSrc_e SRC = pdSrc_e'(PD_SRC);

  logic [NUM_CPU-1:0] wantRun;

  // The debug vector already includes the interrupt wake-up term,
  // so nothing is added to it.
  always_comb begin
    wantRun = (SRC == SRC_DEBUG) ? ~dbgPwrDown : (~cpuIdle | irqPend);
  end

  always_comb begin
    strobes.wake  = wantRun;
    strobes.sleep = ~wantRun;
  end

endmodule

// File: rtl/cpu_clk_gate_dp.sv
module cpu_clk_gate_dp
  import cpu_clk_gate_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter type         strobe_t = logic
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobes,
  output logic [NUM_CPU-1:0] enState,
  output logic [NUM_CPU-1:0] gclk
);

  localparam logic [7:0]         RST_PAT  = resetPattern(NUM_CPU);
  localparam logic [NUM_CPU-1:0] RESET_EN = RST_PAT[NUM_CPU-1:0];

  logic [NUM_CPU-1:0] enReg;

  // Enable register on the free-running clock
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enReg <= RESET_EN;
    else       enReg <= (enReg | strobes.wake) & ~strobes.sleep;
  end

  assign enState = enReg;

  // One glitch-free gate per processor
  for (genvar g = 0; g < NUM_CPU; g++) begin : gGate
    logic enLatch;

    // Transparent while the source clock is low, so the value held
    // during the high phase cannot change mid-pulse
    always_latch begin
      if (!clk) enLatch = enReg[g];
    end

    assign gclk[g] = clk & enLatch;
  end

endmodule

// File: rtl/cpu_clk_gate.sv
module cpu_clk_gate
  import cpu_clk_gate_pkg::*;
#(
  parameter int unsigned NUM_CPU = 4,
  parameter bit          PD_SRC  = 1'b0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CPU-1:0] cpuIdle,
  input  logic [NUM_CPU-1:0] irqPend,
  input  logic [NUM_CPU-1:0] dbgPwrDown,
  output logic [NUM_CPU-1:0] gclk
);

  typedef struct packed {
    logic [NUM_CPU-1:0] wake;
    logic [NUM_CPU-1:0] sleep;
  } strobe_t;

  localparam logic [7:0]         RST_PAT  = resetPattern(NUM_CPU);
  localparam logic [NUM_CPU-1:0] RESET_EN = RST_PAT[NUM_CPU-1:0];

  strobe_t            strobes;
  logic [NUM_CPU-1:0] enState;

  cpu_clk_gate_ctrl #(
    .NUM_CPU (NUM_CPU),
    .PD_SRC  (PD_SRC),
    .strobe_t(strobe_t)
  ) u_ctrl (
    .cpuIdle   (cpuIdle),
    .irqPend   (irqPend),
    .dbgPwrDown(dbgPwrDown),
    .strobes   (strobes)
  );

  cpu_clk_gate_dp #(
    .NUM_CPU (NUM_CPU),
    .strobe_t(strobe_t)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .enState(enState),
    .gclk   (gclk)
  );

  // Checks relating inputs to the registered enable one edge later
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (enState == RESET_EN)); // R5

  for (genvar g = 0; g < NUM_CPU; g++) begin : gChk
    if (PD_SRC == 1'b0) begin : gIdle
      AST_IDLE_SLEEPS: assert property (@(posedge clk) disable iff (!rstN)
        (cpuIdle[g] && !irqPend[g]) |=> !enState[g]); // R1
      AST_IRQ_WAKES: assert property (@(posedge clk) disable iff (!rstN)
        irqPend[g] |=> enState[g]); // R2
      AST_BUSY_RUNS: assert property (@(posedge clk) disable iff (!rstN)
        !cpuIdle[g] |=> enState[g]); // R3
    end else begin : gDbg
      AST_DBG_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> (enState[g] == !$past(dbgPwrDown[g]))); // R4
    end
  end

endmodule

// File: tb/sim_cpu_clk_gate.sv
`timescale 1ns/1ps
module sim_cpu_clk_gate;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN = 1'b1;
  logic [N-1:0] idle0 = '1, irq0 = '0, dbg0 = '0;
  logic [N-1:0] idle1 = '1, irq1 = '0, dbg1 = '1;
  logic [N-1:0] gclk0, gclk1;

  int compared = 0;
  int mismatched = 0;
  int glitches = 0;
  bit armed = 1'b0;
  int cnt0 [N];
  int cnt1 [N];
  int base0 [N];
  int base1 [N];

  always #4 clk = ~clk; // 125 MHz

  cpu_clk_gate #(.NUM_CPU(N), .PD_SRC(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .cpuIdle(idle0), .irqPend(irq0),
    .dbgPwrDown(dbg0), .gclk(gclk0));

  cpu_clk_gate #(.NUM_CPU(N), .PD_SRC(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .cpuIdle(idle1), .irqPend(irq1),
    .dbgPwrDown(dbg1), .gclk(gclk1));

  initial for (int i = 0; i < N; i++) begin cnt0[i] = 0; cnt1[i] = 0; end

  for (genvar g = 0; g < N; g++) begin : gCnt
    always @(posedge gclk0[g]) cnt0[g]++;
    always @(posedge gclk1[g]) cnt1[g]++;
  end

  // R6 monitor: no gated clock may be high during the low phase
  always @(negedge clk) begin
    #1;
    if (armed && (gclk0 != '0 || gclk1 != '0)) glitches++;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic openWin();
    for (int i = 0; i < N; i++) begin base0[i] = cnt0[i]; base1[i] = cnt1[i]; end
  endtask

  function automatic int d0(input int i); return cnt0[i] - base0[i]; endfunction
  function automatic int d1(input int i); return cnt1[i] - base1[i]; endfunction

  task automatic testReset();
    #1 rstN = 1'b0;
    cycles(3);
    armed = 1'b1;
    openWin();
    cycles(4);
    for (int i = 0; i < N; i++) begin
      chk("R5", $sformatf("in reset idle-mode cpu%0d", i), d0(i), (i == 0) ? 4 : 0);
      chk("R5", $sformatf("in reset debug-mode cpu%0d", i), d1(i), (i == 0) ? 4 : 0);
    end
    idle0 = 4'b1110; dbg1 = 4'b1110;
    rstN = 1'b1;
    openWin();
    cycles(4);
    for (int i = 0; i < N; i++)
      chk("R5", $sformatf("after reset cpu%0d", i), d0(i), (i == 0) ? 4 : 0);
  endtask

  task automatic testWake();
    irq0[2] = 1'b1;
    openWin();
    cycles(1);
    chk("R2", "wake edge count after 1 cycle", d0(2), 0);
    cycles(1);
    chk("R2", "wake edge count after 2 cycles", d0(2), 1);
    openWin();
    cycles(5);
    chk("R2", "running while irq held with idle=1", d0(2), 5);
  endtask

  task automatic testSleep();
    irq0[2] = 1'b0;
    cycles(2);
    openWin();
    cycles(6);
    chk("R1", "idle cpu2 gated", d0(2), 0);
    idle0[0] = 1'b1;
    cycles(2);
    openWin();
    cycles(6);
    chk("R1", "idle cpu0 gated", d0(0), 0);
  endtask

  task automatic testBusy();
    idle0[1] = 1'b0;
    openWin();
    cycles(1);
    chk("R3", "busy cpu1 after 1 cycle", d0(1), 0);
    cycles(1);
    chk("R3", "busy cpu1 after 2 cycles", d0(1), 1);
    openWin();
    cycles(7);
    chk("R3", "busy cpu1 steady", d0(1), 7);
    chk("R1", "idle cpu3 untouched", d0(3), 0);
  endtask

  task automatic testDebug();
    idle1 = 4'b0000; irq1 = 4'b1111;
    cycles(2);
    openWin();
    cycles(5);
    for (int i = 0; i < N; i++)
      chk("R4", $sformatf("idle/irq ignored cpu%0d", i), d1(i), (i == 0) ? 5 : 0);
    dbg1 = 4'b0101;
    openWin();
    cycles(1);
    chk("R4", "debug release cpu1 after 1 cycle", d1(1), 0);
    cycles(1);
    chk("R4", "debug release cpu1 after 2 cycles", d1(1), 1);
    chk("R4", "debug release cpu3 after 2 cycles", d1(3), 1);
    idle1 = 4'b1111; irq1 = 4'b0000;
    cycles(2);
    openWin();
    cycles(5);
    chk("R4", "cpu1 runs with idle=1", d1(1), 5);
    chk("R4", "cpu2 stays gated", d1(2), 0);
    chk("R4", "cpu0 stays gated", d1(0), 0);
  endtask

  initial begin : watchdog
    #400000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    testReset();
    testWake();
    testSleep();
    testBusy();
    testDebug();
    chk("R6", "gated clock high in low phase", glitches, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule